// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block is a synchronous controller that runs single-bit read and write cycles on an external asynchronous static memory. The memory holds 4096 one-bit words. It has separate data-in and data-out pins and active-low select and write strobes. The host hands over one request at a time: a direction flag, a 12-bit address and one write bit. The controller then produces the strobe sequence on the memory pins. Every interval of that sequence is a whole number of system clock cycles. Each count is derived at elaboration from the clock period and a nanosecond minimum.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is the inverse of the busy flag. It is low from the cycle after acceptance until the memory cycle, including its recovery, has finished. A host that sees `req_ready` low keeps its request asserted. A request offered while the controller is busy is not stored: it has no effect until `req_ready` rises again.

Read results come back as a one-cycle `rsp_valid` pulse with `rsp_rdata`. The response side has no back-pressure. The host must take the pulse in the cycle it appears. Writes produce no response.

Top module: `asram_cycle_ctrl`

## Requirements
- R1: After reset, `mem_cs_n` and `mem_we_n` are 1, `req_ready` is 1 and `rsp_valid` is 0. Whenever `req_ready` is 1, both strobes are 1.
- R2: A request is accepted on an edge with `req_valid`=1 and `req_ready`=1. From the next cycle, `req_ready` is 0 until the cycle ends. A request presented while `req_ready` is 0 changes no memory pin.
- R3: The direction flag `req_write` uses 1 for a write and 0 for a read. A read drives `mem_cs_n`=0 and `mem_we_n`=1 with a stable address for RD_CYC cycles. RD_CYC is the largest of the cycle counts for access time, select-to-valid time and read cycle time.
- R4: The read bit is sampled from `mem_dout` on the last read cycle. It appears on `rsp_rdata` together with a single-cycle `rsp_valid` pulse, in the same cycle that `mem_cs_n` returns to 1.
- R5: A write drives the address and `mem_din`, with `mem_cs_n`=0 and `mem_we_n`=1, for SU_CYC cycles before `mem_we_n` falls. SU_CYC is the larger of the address set-up count and the select-to-strobe count.
- R6: `mem_we_n` stays 0 for WP_CYC cycles, with `mem_cs_n`=0 throughout. `mem_we_n` and `mem_cs_n` then rise in the same cycle. WP_CYC covers the pulse width. Together with SU_CYC it also covers data set-up, select-to-end and address-to-end.
- R7: After the strobes rise, the address and `mem_din` are held for HD_CYC cycles before `req_ready` returns. HD_CYC covers address hold and data hold, and it stretches the whole write to at least the write cycle time.
- R8: `mem_addr` and `mem_din` change only on an accepting edge, so they never change while `mem_we_n` is 0.
- R9: Each cycle count is the ceiling of nanoseconds divided by the clock period, with a minimum of 1. At a 10 ns clock with the default timings: SU_CYC=3, WP_CYC=6, HD_CYC=5, RD_CYC=14.
- R10: A write never raises `rsp_valid`, and it leaves `rsp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; inverse of busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 1 | Read result bit |
| mem_addr | output | 12 | Memory address pins |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_din | output | 1 | Memory data-in pin |
| mem_dout | input | 1 | Memory data-out pin |

## Verification
The bench drives accesses back to back, with `req_valid` held across the return of `req_ready`. A controller that lets a strobe sequence run into the next request would shift every later pin transition, and this exposes it. Requests with a different address are pulsed while the controller is busy. A design that latches them would move `mem_addr` during a cycle or start a second cycle that was never accepted. Writes of both polarities go to address 0, address 4095 and a mid-range address, and each is read back. An off-by-one in any interval count shifts a strobe edge by a cycle, so the per-cycle pin comparison fails. Sampling `mem_dout` one cycle early or late returns stale data or drops the `rsp_valid` alignment with the select release.

// File: rtl/asram_seq_pkg.sv
package asram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WSET  = 3'd2,
    ST_WLOW  = 3'd3,
    ST_WHOLD = 3'd4
  } seq_state_e;

  // ceiling of ns / period, never below one cycle
  function automatic int ns2cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // remainder of a total still to cover after an earlier phase, floor 1
  function automatic int irest(input int total, input int used);
    return (total - used < 1) ? 1 : total - used;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_pin_driver.sv
module asram_pin_driver #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_write,
  input  logic [AW-1:0] addr_in,
  input  logic          din_in,
  input  logic          we_fall,
  input  logic          release_pins,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_din
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_din  <= 1'b0;
    end else begin
      if (start) begin
        mem_addr <= addr_in;
        mem_cs_n <= 1'b0;
        mem_we_n <= 1'b1;
        if (start_write) mem_din <= din_in;
      end
      if (we_fall)      mem_we_n <= 1'b0;
      if (release_pins) begin
        mem_cs_n <= 1'b1;
        mem_we_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/asram_read_capture.sv
module asram_read_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic dout_in,
  output logic rsp_valid,
  output logic rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= sample;
      if (sample) rsp_rdata <= dout_in;
    end
  end
endmodule

// File: rtl/asram_cycle_ctrl.sv
module asram_cycle_ctrl
  import asram_seq_pkg::*;
#(
  parameter int AW          = 12,
  parameter int CLK_NS      = 10,
  parameter int T_RD_CYC_NS = 135,
  parameter int T_ACC_NS    = 135,
  parameter int T_CS_ACC_NS = 135,
  parameter int T_ASU_NS    = 10,
  parameter int T_AHOLD_NS  = 5,
  parameter int T_WPW_NS    = 50,
  parameter int T_WR_CYC_NS = 135,
  parameter int T_DSU_NS    = 35,
  parameter int T_DHOLD_NS  = 5,
  parameter int T_CS2WE_NS  = 25,
  parameter int T_CS2END_NS = 85,
  parameter int T_A2END_NS  = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          rsp_valid,
  output logic          rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_din,
  input  logic          mem_dout
);
  localparam int SU_CYC = imax(ns2cyc(T_ASU_NS, CLK_NS), ns2cyc(T_CS2WE_NS, CLK_NS));
  localparam int WP_CYC = imax(imax(ns2cyc(T_WPW_NS, CLK_NS),
                                    irest(ns2cyc(T_CS2END_NS, CLK_NS), SU_CYC)),
                               imax(irest(ns2cyc(T_A2END_NS, CLK_NS), SU_CYC),
                                    irest(ns2cyc(T_DSU_NS, CLK_NS), SU_CYC)));
  localparam int HD_CYC = imax(imax(ns2cyc(T_AHOLD_NS, CLK_NS), ns2cyc(T_DHOLD_NS, CLK_NS)),
                               irest(ns2cyc(T_WR_CYC_NS, CLK_NS), SU_CYC + WP_CYC));
  localparam int RD_CYC = imax(ns2cyc(T_RD_CYC_NS, CLK_NS),
                               imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_CS_ACC_NS, CLK_NS)));
  localparam int MAX_CYC = imax(imax(SU_CYC, WP_CYC), imax(HD_CYC, RD_CYC));
  localparam int TW = $clog2(MAX_CYC + 1);

  localparam logic [TW-1:0] SU_LD = TW'(SU_CYC - 1);
  localparam logic [TW-1:0] WP_LD = TW'(WP_CYC - 1);
  localparam logic [TW-1:0] HD_LD = TW'(HD_CYC - 1);
  localparam logic [TW-1:0] RD_LD = TW'(RD_CYC - 1);

  seq_state_e state_q, state_d;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          start, we_fall, release_pins, sample;

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d      = state_q;
    tmr_load     = 1'b0;
    tmr_val      = '0;
    start        = 1'b0;
    we_fall      = 1'b0;
    release_pins = 1'b0;
    sample       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        start    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = req_write ? SU_LD : RD_LD;
        state_d  = req_write ? ST_WSET : ST_READ;
      end
      ST_READ: if (tmr_expired) begin
        sample       = 1'b1;
        release_pins = 1'b1;
        state_d      = ST_IDLE;
      end
      ST_WSET: if (tmr_expired) begin
        we_fall  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = WP_LD;
        state_d  = ST_WLOW;
      end
      ST_WLOW: if (tmr_expired) begin
        release_pins = 1'b1;
        tmr_load     = 1'b1;
        tmr_val      = HD_LD;
        state_d      = ST_WHOLD;
      end
      ST_WHOLD: if (tmr_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  asram_phase_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  asram_pin_driver #(.AW(AW)) u_pins (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(req_write),
    .addr_in(req_addr), .din_in(req_wdata), .we_fall(we_fall),
    .release_pins(release_pins), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_din(mem_din)
  );

  asram_read_capture u_capture (
    .clk(clk), .rst_n(rst_n), .sample(sample), .dout_in(mem_dout),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/asram_cycle_ctrl_chk.sv
module asram_cycle_ctrl_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_din
);
  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_vld_at_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_cs_n && $past(!mem_cs_n && mem_we_n)));

  p_we_under_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  p_we_fall_after_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n));

  p_we_cs_rise_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_cs_n));

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_din)));
endmodule

bind asram_cycle_ctrl asram_cycle_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_we_n(mem_we_n), .mem_din(mem_din)
);

// File: tb/asram_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module asram_cycle_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [11:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata, mem_cs_n, mem_we_n, mem_din, mem_dout;
  logic [11:0] mem_addr;

  always #5 clk = ~clk;

  asram_cycle_ctrl u_asram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_din(mem_din),
    .mem_dout(mem_dout)
  );

  // interval counts from R9, worked out here from the nanosecond minimums
  function automatic int cyc(input int ns);
    int c;
    c = (ns + 9) / 10;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  int NSU, NWP, NHD, NRD;

  // behavioural memory device
  logic [4095:0] dev_store = '0;
  logic wr_arm = 1'b0;
  logic [11:0] wr_a;
  logic wr_d;
  assign mem_dout = (!mem_cs_n && mem_we_n) ? dev_store[mem_addr] : 1'b0;
  always @(negedge clk) begin
    if (!mem_cs_n && !mem_we_n) begin
      wr_arm = 1'b1; wr_a = mem_addr; wr_d = mem_din;
    end else if (wr_arm) begin
      dev_store[wr_a] = wr_d; wr_arm = 1'b0;
    end
  end

  // reference model
  logic [4095:0] gold = '0;
  int  m_k = 0;
  bit  m_busy = 0, m_wr = 0, m_cs = 1, m_we = 1, m_din = 0, m_vld = 0, m_rd = 0, m_acc = 0;
  logic [11:0] m_addr = '0;
  always @(posedge clk) begin
    m_acc = 0;
    if (!rst_n) begin
      m_k = 0; m_busy = 0; m_cs = 1; m_we = 1; m_din = 0; m_vld = 0; m_rd = 0; m_addr = '0;
    end else begin
      m_vld = 0;
      if (!m_busy) begin
        if (req_valid) begin
          m_acc = 1; m_busy = 1; m_k = 0; m_wr = req_write;
          m_addr = req_addr; m_cs = 0; m_we = 1;
          if (req_write) m_din = req_wdata;
        end
      end else begin
        m_k++;
        if (m_wr) begin
          if (m_k == NSU) m_we = 0;
          if (m_k == NSU + NWP) begin m_we = 1; m_cs = 1; gold[m_addr] = m_din; end
          if (m_k == NSU + NWP + NHD) m_busy = 0;
        end else if (m_k == NRD) begin
          m_vld = 1; m_rd = gold[m_addr]; m_cs = 1; m_busy = 0;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    chk("R2 req_ready", req_ready, !m_busy);
    chk("R3/R5/R6 mem_cs_n", mem_cs_n, m_cs);
    chk("R5/R6 mem_we_n", mem_we_n, m_we);
    chk("R8/R7 mem_addr", mem_addr, m_addr);
    chk("R8/R7 mem_din", mem_din, m_din);
    chk("R4/R10 rsp_valid", rsp_valid, m_vld);
    chk("R4/R10 rsp_rdata", rsp_rdata, m_rd);
  end

  task automatic issue(input bit w, input logic [11:0] a, input bit d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!m_acc);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
  endtask

  int rd_len, wr_len;
  initial begin
    NSU = mx(cyc(10), cyc(25));
    NWP = mx(mx(cyc(50), mx(1, cyc(85) - NSU)), mx(mx(1, cyc(80) - NSU), mx(1, cyc(35) - NSU)));
    NHD = mx(mx(cyc(5), cyc(5)), mx(1, cyc(135) - NSU - NWP));
    NRD = mx(cyc(135), cyc(135));
    chk("R9 SU_CYC", NSU, 3);
    chk("R9 WP_CYC", NWP, 6);
    chk("R9 HD_CYC", NHD, 5);
    chk("R9 RD_CYC", NRD, 14);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", mem_cs_n, 1);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1;
    cmp_on = 1;

    // R3 unwritten location reads zero
    issue(0, 12'h000, 0); wait_idle();
    // writes of both polarities at the address range ends and middle
    issue(1, 12'h000, 1); wait_idle();
    issue(1, 12'hFFF, 1); wait_idle();
    issue(1, 12'h5A5, 0); wait_idle();
    issue(1, 12'h5A5, 1); wait_idle();
    issue(0, 12'h000, 0); wait_idle();
    issue(0, 12'hFFF, 0); wait_idle();
    issue(0, 12'h5A5, 0); wait_idle();

    // R2: requests pulsed while busy must be ignored
    issue(1, 12'h3C3, 1);
    repeat (2) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 12'h111; req_wdata = 0;
    @(negedge clk); req_valid = 0;
    repeat (8) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 12'h222;
    @(negedge clk); req_valid = 0;
    wait_idle();
    chk("R2 ignored request left address", mem_addr, 12'h3C3);
    @(negedge clk);
    chk("R2 no cycle started by ignored request", mem_cs_n, 1);

    // back-to-back with valid held: R7 hold then immediate next cycle
    issue(1, 12'h3C3, 0);
    issue(0, 12'h3C3, 0);
    issue(0, 12'h111, 0);
    wait_idle();

    // R3 read cycle length measured at the pins
    issue(0, 12'hFFF, 0);
    rd_len = 1;
    while (!mem_cs_n) begin @(negedge clk); if (!mem_cs_n) rd_len++; end
    chk("R3 read select length", rd_len, 14);
    wait_idle();
    // R6 write strobe length
    issue(1, 12'h7E7, 1);
    while (mem_we_n) @(negedge clk);
    wr_len = 0;
    while (!mem_we_n) begin wr_len++; @(negedge clk); end
    chk("R6 write strobe length", wr_len, 6);
    wait_idle();
    issue(0, 12'h7E7, 0); wait_idle();
    @(negedge clk);
    chk("R4 last read bit", rsp_rdata, 1);

    cmp_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule